// File: doc/BRIEF.md
# Serial Write-Only Mode Register Port

This block is a three-wire serial slave that programs a bank of ten 8-bit mode registers. An external controller lowers an active-low select, clocks bits in on the rising edge of a serial clock, and raises select to finish the access. The port needs no fixed phase relation to the host clock. All three serial lines are brought into the fast system clock domain through two-flop synchronizers, and their edges are detected there. For this reason the system clock must run at least four times faster than the serial clock.

A frame starts with a direction bit, which must be 0. Seven address bits follow, most significant bit first, and then eight data bits, most significant bit first. The two upper address bits are compared against two strap inputs, so up to four devices can share the wires. After the first data byte the controller may keep select low and send more bytes. These are written to the next addresses in turn. Two bits of the register at the lowest address act as self-restoring triggers: one returns the whole bank to defaults, and the other issues a resynchronization pulse.

The register contents are plain levels. Each register also has a one-cycle load strobe. There is no handshake and no back-pressure: a consumer must take each strobe in the cycle it appears.

Top module: `ctlport_spi_wr`

## Requirements
- R1: After reset the bank holds its defaults: index 0 (address low bits 0x10) = 0xC0, indices 8 and 9 (0x18, 0x19) = 0xFF, all other registers = 0x00. No strobe and no resync pulse are active.
- R2: Register index i occupies regs_flat[8i+7:8i]. A frame is sel_n low followed by 16 rising sck edges, carrying the direction bit, 7 address bits and 8 data bits, each field MSB first. The data is loaded into register (address[4:0] − 0x10) after sel_n rises, and that register's wr_stb bit pulses for one cycle.
- R3: A frame whose direction bit is 1 changes no register and raises no strobe, including its burst bytes.
- R4: A frame whose address bit 6 differs from strap_a6, or whose address bit 5 differs from strap_a5, is ignored.
- R5: If sel_n rises before the 16th rising sck edge, nothing is written. A trailing burst byte with fewer than 8 clocks is also discarded.
- R6: While sel_n stays low after the first data byte, each further complete group of 8 clocks is data for address first+k, where k is the 1-based byte number. Every byte is written in order.
- R7: At most 9 burst bytes are accepted after the first data byte. Any clocks after that are ignored until sel_n rises.
- R8: A byte whose address low five bits lie outside 0x10..0x19 is discarded with no strobe. The other bytes of the same burst are still written.
- R9: Writing index 0 with bit 6 = 0 produces a one-cycle sys_resync pulse. Bits 7 and 6 of index 0 always read 1.
- R10: Writing index 0 with bit 7 = 0 restores every register to its R1 default and pulses every wr_stb bit once. The other bits of that byte are dropped.
- R11: A register changes only in the cycle its wr_stb bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_a6 | input | 1 | Required value of address bit 6 |
| strap_a5 | input | 1 | Required value of address bit 5 |
| sel_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, data taken on rising edge |
| sdi | input | 1 | Serial data |
| regs_flat | output | 80 | Register contents, index i at bits 8i+7:8i |
| wr_stb | output | 10 | Per-register one-cycle load strobe |
| sys_resync | output | 1 | One-cycle resynchronization request |

## Verification
Directed frames cover the following cases:
- a lone single write, to show that address and data are decoded in the right bit order;
- a frame with the direction bit set, to tell a correct decode from one that ignores the direction bit;
- a strap mismatch;
- a frame cut short, and a burst whose last byte is cut short, to separate byte-complete from clock-count commits;
- a burst starting below the window, so that it distinguishes the nine-byte cap from the range check;
- both trigger bits of index 0.

Random frames then mix strap changes, burst lengths from 0 to 10, and in- and out-of-range starts. Each is compared against a bench model of register contents, strobe counts and resync counts.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int NREG      = 10;
  localparam logic [4:0] WIN_BASE = 5'h10;
  localparam int MAX_EXTRA = 9;
  localparam int TRIG_ALL_BIT  = 7;
  localparam int TRIG_SYNC_BIT = 6;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'hC0;
      8, 9:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= d_async[b];
        stab_q <= meta_q;
      end
    end
    assign q_sync[b] = stab_q;
  end
endmodule

// File: rtl/ctlport_deframe.sv
module ctlport_deframe #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int MAX_EXTRA = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_fall,
  input  logic          sel_rise,
  input  logic          sck_rise,
  input  logic          sdi_s,
  input  logic [1:0]    strap,
  output logic          go,
  output logic [AW-1:0] go_addr,
  output logic [DW-1:0] go_data
);
  localparam int HDR = 1 + AW + DW;
  localparam int CW  = $clog2(HDR + 1);
  localparam int XW  = $clog2(MAX_EXTRA + 1);
  localparam int BW  = $clog2(DW);

  logic          active, frame_ok, pend_v;
  logic [CW-1:0] hdr_cnt;
  logic [BW-1:0] body_bit;
  logic [XW-1:0] xcnt;
  logic [DW-2:0] sh;
  logic [AW-1:0] hdr_addr, pend_addr;
  logic [DW-1:0] pend_data;
  logic [DW-1:0] byte_now;
  logic          in_hdr, take_clk;

  assign byte_now = {sh, sdi_s};
  assign in_hdr   = (hdr_cnt != CW'(HDR));
  assign take_clk = active && sck_rise && (xcnt != XW'(MAX_EXTRA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; frame_ok <= 1'b0; pend_v <= 1'b0;
      hdr_cnt <= '0; body_bit <= '0; xcnt <= '0; sh <= '0;
      hdr_addr <= '0; pend_addr <= '0; pend_data <= '0;
      go <= 1'b0; go_addr <= '0; go_data <= '0;
    end else begin
      go <= 1'b0;
      if (sel_fall) begin
        active   <= 1'b1;
        frame_ok <= 1'b1;
        pend_v   <= 1'b0;
        hdr_cnt  <= '0;
        body_bit <= '0;
        xcnt     <= '0;
      end else if (sel_rise) begin
        active <= 1'b0;
        pend_v <= 1'b0;
        if (pend_v) begin
          go      <= 1'b1;
          go_addr <= pend_addr;
          go_data <= pend_data;
        end
      end else if (take_clk) begin
        sh <= byte_now[DW-2:0];
        if (in_hdr) begin
          hdr_cnt <= hdr_cnt + CW'(1);
          if (hdr_cnt == '0 && sdi_s) frame_ok <= 1'b0;
          if (hdr_cnt == CW'(AW)) begin
            hdr_addr <= {sh[AW-2:0], sdi_s};
            if ({sh[AW-2], sh[AW-3]} != strap) frame_ok <= 1'b0;
          end
          if (hdr_cnt == CW'(HDR-1)) begin
            pend_v    <= frame_ok;
            pend_addr <= hdr_addr;
            pend_data <= byte_now;
          end
        end else begin
          if (body_bit == BW'(DW-1)) begin
            body_bit <= '0;
            xcnt     <= xcnt + XW'(1);
            if (pend_v) begin
              go        <= 1'b1;
              go_addr   <= pend_addr;
              go_data   <= pend_data;
              pend_addr <= hdr_addr + AW'(xcnt) + AW'(1);
              pend_data <= byte_now;
            end
          end else begin
            body_bit <= body_bit + BW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctlport_regbank.sv
module ctlport_regbank
  import ctlport_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int N  = 10,
  parameter logic [4:0] BASE = 5'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  input  logic [1:0]      strap,
  output logic [N*DW-1:0] regs_flat,
  output logic [N-1:0]    wr_stb,
  output logic            sys_resync
);
  localparam logic [5:0] LIMIT = 6'(BASE) + 6'(N);

  logic [4:0] lo, idx;
  logic       hit, hit0, wipe;

  assign lo   = addr[4:0];
  assign idx  = lo - BASE;
  assign hit  = go && (addr[AW-1:AW-2] == strap) && (lo >= BASE) && ({1'b0, lo} < LIMIT);
  assign hit0 = hit && (idx == 5'd0);
  assign wipe = hit0 && !data[TRIG_ALL_BIT];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [DW-1:0] r_q;
    logic          stb_q;
    logic          sel_i;
    logic [DW-1:0] wval;
    assign sel_i = hit && (idx == 5'(i));
    if (i == 0) begin : g_ctl
      always_comb begin
        wval = data;
        wval[TRIG_ALL_BIT]  = 1'b1;
        wval[TRIG_SYNC_BIT] = 1'b1;
      end
    end else begin : g_plain
      assign wval = data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q   <= reg_default(i);
        stb_q <= 1'b0;
      end else begin
        stb_q <= wipe || sel_i;
        if (wipe)       r_q <= reg_default(i);
        else if (sel_i) r_q <= wval;
      end
    end
    assign regs_flat[i*DW +: DW] = r_q;
    assign wr_stb[i] = stb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_resync <= 1'b0;
    else        sys_resync <= hit0 && !data[TRIG_SYNC_BIT];
  end
endmodule

// File: rtl/ctlport_spi_wr.sv
module ctlport_spi_wr
  import ctlport_pkg::*;
#(
  parameter int NREG_P = NREG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_a6,
  input  logic                   strap_a5,
  input  logic                   sel_n,
  input  logic                   sck,
  input  logic                   sdi,
  output logic [NREG_P*DATA_W-1:0] regs_flat,
  output logic [NREG_P-1:0]      wr_stb,
  output logic                   sys_resync
);
  logic [2:0] raw, synced;
  logic       sel_s, sck_s, sdi_s;
  logic       sel_d, sck_d;
  logic       sel_fall, sel_rise, sck_rise;
  logic       go;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_data;

  assign raw = {sel_n, sck, sdi};

  ctlport_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw), .q_sync(synced)
  );

  assign {sel_s, sck_s, sdi_s} = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      sel_d <= sel_s;
      sck_d <= sck_s;
    end
  end

  assign sel_fall = sel_d && !sel_s;
  assign sel_rise = !sel_d && sel_s;
  assign sck_rise = sck_s && !sck_d;

  ctlport_deframe #(.AW(ADDR_W), .DW(DATA_W), .MAX_EXTRA(MAX_EXTRA)) u_deframe (
    .clk(clk), .rst_n(rst_n),
    .sel_fall(sel_fall), .sel_rise(sel_rise), .sck_rise(sck_rise),
    .sdi_s(sdi_s), .strap({strap_a6, strap_a5}),
    .go(go), .go_addr(go_addr), .go_data(go_data)
  );

  ctlport_regbank #(.AW(ADDR_W), .DW(DATA_W), .N(NREG_P), .BASE(WIN_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .go(go), .addr(go_addr), .data(go_data), .strap({strap_a6, strap_a5}),
    .regs_flat(regs_flat), .wr_stb(wr_stb), .sys_resync(sys_resync)
  );
endmodule

// File: rtl/ctlport_spi_wr_chk.sv
module ctlport_spi_wr_chk
  import ctlport_pkg::*;
#(
  parameter int NREG_P = NREG
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NREG_P*DATA_W-1:0] regs_flat,
  input logic [NREG_P-1:0]        wr_stb,
  input logic                     sys_resync
);
  for (genvar i = 0; i < NREG_P; i++) begin : g_chk
    // R1
    reg_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs_flat[i*DATA_W +: DATA_W] == reg_default(i)));
    // R11
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb[i] |-> $stable(regs_flat[i*DATA_W +: DATA_W]));
  end

  // R9
  trig_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[TRIG_ALL_BIT:TRIG_SYNC_BIT] == 2'b11);

  // R10
  stb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_stb) <= 1) || (&wr_stb));

  // R9
  resync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_resync |=> !sys_resync);
endmodule

bind ctlport_spi_wr ctlport_spi_wr_chk #(.NREG_P(NREG_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .regs_flat(regs_flat),
  .wr_stb(wr_stb), .sys_resync(sys_resync)
);

// File: tb/ctlport_spi_wr_test.sv
`timescale 1ns/1ps
module ctlport_spi_wr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s6 = 1'b1, s5 = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [79:0] regs_flat;
  logic [9:0]  wr_stb;
  logic        sys_resync;

  int checks = 0, failures = 0;
  int exp_stb = 0, exp_resync = 0, obs_stb = 0, obs_resync = 0;
  bit done = 0;
  logic [7:0] exp_r [10];

  always #2.5 clk = ~clk;

  ctlport_spi_wr uut (
    .clk(clk), .rst_n(rst_n), .strap_a6(s6), .strap_a5(s5),
    .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .regs_flat(regs_flat), .wr_stb(wr_stb), .sys_resync(sys_resync)
  );

  always @(negedge clk) if (rst_n) begin
    obs_stb    += $countones(wr_stb);
    obs_resync += int'(sys_resync);
  end

  function automatic logic [7:0] dflt(int i);
    if (i == 0) return 8'hC0;
    if (i >= 8) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic reset_model();
    for (int i = 0; i < 10; i++) exp_r[i] = dflt(i);
  endtask

  task automatic model_write(input logic [6:0] a, input logic [7:0] d);
    int i;
    if (a[6:5] == {s6, s5} && a[4:0] >= 5'h10 && a[4:0] <= 5'h19) begin
      i = int'(a[4:0]) - 16;
      if (i == 0) begin
        if (!d[6]) exp_resync++;
        if (!d[7]) begin reset_model(); exp_stb += 10; end
        else begin exp_r[0] = {2'b11, d[5:0]}; exp_stb++; end
      end else begin
        exp_r[i] = d;
        exp_stb++;
      end
    end
  endtask

  task automatic check_all(input string tag);
    logic [79:0] e;
    for (int i = 0; i < 10; i++) e[i*8 +: 8] = exp_r[i];
    checks++;
    if (regs_flat !== e) begin
      failures++;
      $display("FAIL %s regs actual=%h expected=%h", tag, regs_flat, e);
    end
    checks++;
    if (obs_stb != exp_stb) begin
      failures++;
      $display("FAIL %s strobes actual=%0d expected=%0d", tag, obs_stb, exp_stb);
    end
    checks++;
    if (obs_resync != exp_resync) begin
      failures++;
      $display("FAIL %s resync actual=%0d expected=%0d", tag, obs_resync, exp_resync);
    end
  endtask

  task automatic sck_bit(input logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sck_bit(b[i]);
  endtask

  task automatic sel_open();
    sel_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel_close();
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  task automatic frame(input logic wb, input logic [6:0] a, input logic [7:0] d0,
                       input int nx, input logic [7:0] xbase, input bit rnd);
    bit valid;
    logic [7:0] d;
    valid = !wb && (a[6:5] == {s6, s5});
    sel_open();
    sck_bit(wb);
    for (int i = 6; i >= 0; i--) sck_bit(a[i]);
    send_byte(d0);
    if (valid) model_write(a, d0);
    for (int k = 1; k <= nx; k++) begin
      d = rnd ? 8'($urandom) : xbase + 8'(k);
      send_byte(d);
      if (valid && k <= 9) model_write(a + 7'(k), d);
    end
    sel_close();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    reset_model();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 reset");

    frame(1'b0, 7'b1010011, 8'hA5, 0, 8'h00, 0);
    check_all("R2 single");

    frame(1'b1, 7'b1010100, 8'h3C, 2, 8'h50, 0);
    check_all("R3 read bit");

    frame(1'b0, 7'b0110101, 8'h77, 0, 8'h00, 0);
    check_all("R4 strap6");
    frame(1'b0, 7'b1110101, 8'h77, 0, 8'h00, 0);
    check_all("R4 strap5");

    sel_open();
    sck_bit(1'b0);
    for (int i = 6; i >= 0; i--) sck_bit(1'b1);
    for (int i = 0; i < 4; i++) sck_bit(1'b0);
    sel_close();
    check_all("R5 short header");

    sel_open();
    sck_bit(1'b0);
    send_byte(8'h0) ;
    sel_close();
    check_all("R5 one byte only");

    sel_open();
    sck_bit(1'b0);
    for (int i = 6; i >= 0; i--) sck_bit(((7'b1010100) >> i) & 1);
    send_byte(8'h11);
    model_write(7'b1010100, 8'h11);
    for (int i = 0; i < 5; i++) sck_bit(1'b1);
    sel_close();
    check_all("R5 partial burst byte");

    frame(1'b0, 7'b1010001, 8'hC1, 3, 8'h20, 0);
    check_all("R6 burst");

    frame(1'b0, 7'b1001111, 8'h99, 10, 8'hC3, 0);
    check_all("R7 R8 cap and window");

    frame(1'b0, 7'b1010000, 8'h85, 0, 8'h00, 0);
    check_all("R9 resync");

    frame(1'b0, 7'b1010000, 8'h40, 0, 8'h00, 0);
    check_all("R10 wipe");

    for (int n = 0; n < 60; n++) begin
      logic wb;
      logic [6:0] a;
      int nx;
      if ($urandom_range(7) == 0) begin s6 = 1'($urandom); s5 = 1'($urandom); end
      wb = ($urandom_range(7) == 0);
      a[4:0] = 5'($urandom_range(5'h0E, 5'h1B));
      a[6:5] = ($urandom_range(7) == 0) ? 2'($urandom) : {s6, s5};
      nx = $urandom_range(10);
      frame(wb, a, 8'($urandom), nx, 8'h00, 1);
      check_all("R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule